// File: doc/BRIEF.md
# UART Interrupt Identification and Prioritizer

This block sits between the condition sources of one UART channel and the register that software reads to learn why the channel raised its interrupt. It accepts receive-line error events, the receive FIFO trigger level, receive time-out events, the transmit FIFO trigger state, modem-line delta events, special-character matches and a flow-control (CTS/RTS) change level. It keeps the sticky ones as pending flags and gates every source with its own enable bit. It then reports the most urgent enabled source as a 6-bit identification code, together with an interrupt request line.

Each source has its own clear rule. Line errors clear when the line status register is read. Modem deltas clear when the modem status register is read. The time-out clears when the receive holding register is read. The transmit-empty and special-character flags clear only when the identification register is read while it shows them. The level sources follow their inputs. The two lowest levels exist only in enhanced mode, and in basic mode bit 5 of the code is always 0.

Top module: `uart_int_id`

## Requirements
- R1: The code is 000001 (bit 0 set) exactly when no enabled source is pending, and `irq` is the inverse of code bit 0. Source codes are: line status 000110, receive data 000100, time-out 001100, transmit empty 000010, modem 000000, special character 010000, flow change 100000.
- R2: Priority from highest to lowest is line status, receive level (data, then time-out), transmit empty, modem, special character, flow change.
- R3: Receive data available follows `rx_above_trig` directly and wins over a pending time-out.
- R4: Any bit of `rx_err_evt` sets a sticky line-status flag on the next edge. A `lsr_rd` strobe clears it, and a new event in the same cycle takes precedence.
- R5: `rx_tmo_evt` sets a sticky time-out flag that `rhr_rd` clears.
- R6: The transmit-empty flag sets on a rising edge of the transmit condition. It clears when `isr_rd` is strobed while the code shows 000010, or when the condition drops. It re-arms on the next rising edge.
- R7: When `tx_trig_zero` is 1, the transmit condition is `tx_all_idle` (FIFO and shifter empty, line marking) rather than `tx_below_trig`.
- R8: Any bit of `ms_delta_evt` sets a sticky modem flag that `msr_rd` clears.
- R9: The special-character flag is reported only when `enh_mode` is 1. It clears when `isr_rd` is strobed while the code shows 010000.
- R10: `flow_chg` is reported as a level only when `enh_mode` is 1. With `enh_mode` 0, code bit 5 is always 0.
- R11: `int_en` bit positions are: 0 receive data and time-out, 1 transmit empty, 2 line status, 3 modem, 4 special character, 5 flow change. A disabled source is not reported and does not hide a lower one. Its pending flag is kept and shows again once it is re-enabled.
- R12: An `isr_rd` strobe clears only the source shown in that cycle. Sources whose clear rule lies elsewhere are not affected by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enh_mode | input | 1 | 1 enables the two enhanced levels |
| int_en | input | 6 | Per-source enable bits |
| rx_err_evt | input | 4 | Parity/overrun/framing/break event pulses |
| rx_above_trig | input | 1 | Receive FIFO above trigger level |
| rx_tmo_evt | input | 1 | Receive time-out event pulse |
| tx_below_trig | input | 1 | Transmit FIFO below trigger level |
| tx_trig_zero | input | 1 | Transmit trigger level is zero |
| tx_all_idle | input | 1 | Transmit FIFO and shifter empty, line at mark |
| ms_delta_evt | input | 4 | Modem delta event pulses |
| spc_match_evt | input | 1 | Special-character match pulse |
| flow_chg | input | 1 | CTS/RTS change level |
| isr_rd | input | 1 | Identification register read strobe |
| lsr_rd | input | 1 | Line status read strobe |
| msr_rd | input | 1 | Modem status read strobe |
| rhr_rd | input | 1 | Receive holding register read strobe |
| int_id | output | 6 | Identification code |
| irq | output | 1 | Interrupt request |

## Verification
The clear properties assume that the read strobes and event pulses are single-cycle and synchronous to `clk`. They allow that an event may coincide with a read, and in that case they do not demand the clear. The transmit clear property relies on the pending transmit flag existing only while its condition is high. The stimulus respects this: it raises events and strobes for exactly one edge, changes levels only at the falling clock edge, and checks each clear in a cycle with no competing event.

// File: rtl/uart_int_pkg.sv
// Package: identification codes, enable bit positions and the pending-set type
// shared by the interrupt identification block and its checker.
package uart_int_pkg;
    localparam int ID_W = 6;
    localparam int EN_W = 6;

    localparam logic [ID_W-1:0] ID_NONE = 6'b000001;
    localparam logic [ID_W-1:0] ID_LS   = 6'b000110;
    localparam logic [ID_W-1:0] ID_RXD  = 6'b000100;
    localparam logic [ID_W-1:0] ID_TMO  = 6'b001100;
    localparam logic [ID_W-1:0] ID_TX   = 6'b000010;
    localparam logic [ID_W-1:0] ID_MS   = 6'b000000;
    localparam logic [ID_W-1:0] ID_SPC  = 6'b010000;
    localparam logic [ID_W-1:0] ID_FLOW = 6'b100000;

    localparam int EN_RX   = 0;
    localparam int EN_TX   = 1;
    localparam int EN_LS   = 2;
    localparam int EN_MS   = 3;
    localparam int EN_SPC  = 4;
    localparam int EN_FLOW = 5;

    typedef struct packed {
        logic flow;
        logic spc;
        logic ms;
        logic tx;
        logic tmo;
        logic rxd;
        logic ls;
    } pend_t;
endpackage

// File: rtl/int_sticky.sv
// Sticky flag bank: W event bits held until a clear strobe.
// Assumes events are single-cycle pulses; a same-cycle event beats the clear.
module int_sticky #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic         any_o
);
    logic [W-1:0] bits_q;

    // Hold each event bit until cleared; new events win over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= (bits_q & ~{W{clr_i}}) | set_i;
    end

    assign any_o = |bits_q;
endmodule

// File: rtl/uart_int_src.sv
// Source stage: builds the pending set from raw conditions and applies each
// source's own clear rule. Assumes read strobes last one cycle and the
// "shown" clears are qualified by the code visible in the same cycle.
module uart_int_src #(
    parameter int ERR_W = 4,
    parameter int MS_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ERR_W-1:0]   rx_err_evt,
    input  logic               rx_above_trig,
    input  logic               rx_tmo_evt,
    input  logic               tx_below_trig,
    input  logic               tx_trig_zero,
    input  logic               tx_all_idle,
    input  logic [MS_W-1:0]    ms_delta_evt,
    input  logic               spc_match_evt,
    input  logic               flow_chg,
    input  logic               lsr_rd,
    input  logic               msr_rd,
    input  logic               rhr_rd,
    input  logic               tx_shown_rd,
    input  logic               spc_shown_rd,
    output uart_int_pkg::pend_t pend
);
    localparam int N_STICKY = 4;

    logic              tx_cond;
    logic              tx_prev_q;
    logic              tx_pend_q;
    logic [N_STICKY-1:0] st_any;

    // Sticky sources: line status, time-out, modem, special character.
    genvar gi;
    generate
        for (gi = 0; gi < N_STICKY; gi++) begin : g_stk
            if (gi == 0) begin : g_ls
                int_sticky #(.W(ERR_W)) u_stk (.clk(clk), .rst_n(rst_n),
                    .set_i(rx_err_evt), .clr_i(lsr_rd), .any_o(st_any[gi]));
            end else if (gi == 1) begin : g_tmo
                int_sticky #(.W(1)) u_stk (.clk(clk), .rst_n(rst_n),
                    .set_i(rx_tmo_evt), .clr_i(rhr_rd), .any_o(st_any[gi]));
            end else if (gi == 2) begin : g_ms
                int_sticky #(.W(MS_W)) u_stk (.clk(clk), .rst_n(rst_n),
                    .set_i(ms_delta_evt), .clr_i(msr_rd), .any_o(st_any[gi]));
            end else begin : g_spc
                int_sticky #(.W(1)) u_stk (.clk(clk), .rst_n(rst_n),
                    .set_i(spc_match_evt), .clr_i(spc_shown_rd), .any_o(st_any[gi]));
            end
        end
    endgenerate

    // Transmit condition: zero trigger waits for a fully idle transmitter.
    always_comb tx_cond = tx_trig_zero ? tx_all_idle : tx_below_trig;

    // Transmit-empty flag: set on condition rise, drop on shown read or loss of condition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_prev_q <= 1'b0;
            tx_pend_q <= 1'b0;
        end else begin
            tx_prev_q <= tx_cond;
            tx_pend_q <= (tx_cond & ~tx_prev_q) | (tx_pend_q & tx_cond & ~tx_shown_rd);
        end
    end

    // Gather the pending set for the prioritizer.
    always_comb begin
        pend.ls   = st_any[0];
        pend.rxd  = rx_above_trig;
        pend.tmo  = st_any[1];
        pend.tx   = tx_pend_q;
        pend.ms   = st_any[2];
        pend.spc  = st_any[3];
        pend.flow = flow_chg;
    end
endmodule

// File: rtl/uart_int_prio.sv
// Prioritizer: masks the pending set with the enables and enhanced mode, then
// returns the code of the highest enabled source. Purely combinational.
module uart_int_prio
    import uart_int_pkg::*;
(
    input  pend_t            pend,
    input  logic [EN_W-1:0]  int_en,
    input  logic             enh_mode,
    output logic [ID_W-1:0]  int_id
);
    localparam int N_SRC = 7;

    logic [N_SRC-1:0]  req;
    logic [ID_W-1:0]   code [N_SRC];
    logic [ID_W-1:0]   pick;

    // Requests listed from highest (index 0) to lowest priority.
    always_comb begin
        req[0] = pend.ls   & int_en[EN_LS];
        req[1] = pend.rxd  & int_en[EN_RX];
        req[2] = pend.tmo  & int_en[EN_RX];
        req[3] = pend.tx   & int_en[EN_TX];
        req[4] = pend.ms   & int_en[EN_MS];
        req[5] = pend.spc  & int_en[EN_SPC]  & enh_mode;
        req[6] = pend.flow & int_en[EN_FLOW] & enh_mode;
        code[0] = ID_LS;
        code[1] = ID_RXD;
        code[2] = ID_TMO;
        code[3] = ID_TX;
        code[4] = ID_MS;
        code[5] = ID_SPC;
        code[6] = ID_FLOW;
    end

    // Walk from lowest to highest so the most urgent request overrides.
    always_comb begin
        pick = ID_NONE;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req[i]) pick = code[i];
        end
        int_id = pick;
        if (!enh_mode) int_id[ID_W-1] = 1'b0;
    end
endmodule

// File: rtl/uart_int_id.sv
// Top: interrupt identification for one UART channel. Pending flags are
// registered; the code is combinational from them. Assumes all strobes and
// events are synchronous single-cycle pulses.
module uart_int_id
    import uart_int_pkg::*;
#(
    parameter int ERR_W = 4,
    parameter int MS_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enh_mode,
    input  logic [EN_W-1:0]   int_en,
    input  logic [ERR_W-1:0]  rx_err_evt,
    input  logic              rx_above_trig,
    input  logic              rx_tmo_evt,
    input  logic              tx_below_trig,
    input  logic              tx_trig_zero,
    input  logic              tx_all_idle,
    input  logic [MS_W-1:0]   ms_delta_evt,
    input  logic              spc_match_evt,
    input  logic              flow_chg,
    input  logic              isr_rd,
    input  logic              lsr_rd,
    input  logic              msr_rd,
    input  logic              rhr_rd,
    output logic [ID_W-1:0]   int_id,
    output logic              irq
);
    pend_t pend;
    logic  tx_shown_rd;
    logic  spc_shown_rd;

    // Clear-on-identification-read applies only to the source on display.
    always_comb begin
        tx_shown_rd  = isr_rd & (int_id == ID_TX);
        spc_shown_rd = isr_rd & (int_id == ID_SPC);
    end

    uart_int_src #(.ERR_W(ERR_W), .MS_W(MS_W)) u_src (
        .clk(clk), .rst_n(rst_n),
        .rx_err_evt(rx_err_evt), .rx_above_trig(rx_above_trig),
        .rx_tmo_evt(rx_tmo_evt), .tx_below_trig(tx_below_trig),
        .tx_trig_zero(tx_trig_zero), .tx_all_idle(tx_all_idle),
        .ms_delta_evt(ms_delta_evt), .spc_match_evt(spc_match_evt),
        .flow_chg(flow_chg), .lsr_rd(lsr_rd), .msr_rd(msr_rd),
        .rhr_rd(rhr_rd), .tx_shown_rd(tx_shown_rd),
        .spc_shown_rd(spc_shown_rd), .pend(pend)
    );

    uart_int_prio u_prio (
        .pend(pend), .int_en(int_en), .enh_mode(enh_mode), .int_id(int_id)
    );

    // Request line mirrors "something pending".
    always_comb irq = ~int_id[0];
endmodule

// File: rtl/uart_int_id_chk.sv
// Checker: temporal properties of the identification block, bound to the top.
// Assumes single-cycle strobes and events.
module uart_int_id_chk
    import uart_int_pkg::*;
#(
    parameter int ERR_W = 4,
    parameter int MS_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enh_mode,
    input logic [EN_W-1:0]   int_en,
    input logic [ERR_W-1:0]  rx_err_evt,
    input logic              rx_tmo_evt,
    input logic [MS_W-1:0]   ms_delta_evt,
    input logic              isr_rd,
    input logic              lsr_rd,
    input logic              msr_rd,
    input logic              rhr_rd,
    input logic [ID_W-1:0]   int_id,
    input pend_t             pend
);
    AST_LS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend.ls && int_en[EN_LS]) |-> (int_id == ID_LS));  // R2
    AST_NONE_MEANS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (int_id == ID_NONE) |-> !((pend.ls && int_en[EN_LS]) || (pend.ms && int_en[EN_MS]) || (pend.tx && int_en[EN_TX])));  // R1
    AST_BASIC_BIT5: assert property (@(posedge clk) disable iff (!rst_n)
        !enh_mode |-> !int_id[ID_W-1]);  // R10
    AST_LSR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && rx_err_evt == '0) |=> !pend.ls);  // R4
    AST_RHR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rhr_rd && !rx_tmo_evt) |=> !pend.tmo);  // R5
    AST_TX_SHOWN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_rd && int_id == ID_TX) |=> !pend.tx);  // R6
    AST_MSR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && ms_delta_evt == '0) |=> !pend.ms);  // R8
    AST_ISR_SPARES_MS: assert property (@(posedge clk) disable iff (!rst_n)
        (isr_rd && pend.ms && !msr_rd) |=> pend.ms);  // R12
endmodule

bind uart_int_id uart_int_id_chk #(.ERR_W(ERR_W), .MS_W(MS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .enh_mode(enh_mode), .int_en(int_en),
    .rx_err_evt(rx_err_evt), .rx_tmo_evt(rx_tmo_evt),
    .ms_delta_evt(ms_delta_evt), .isr_rd(isr_rd), .lsr_rd(lsr_rd),
    .msr_rd(msr_rd), .rhr_rd(rhr_rd), .int_id(int_id), .pend(pend)
);

// File: tb/tb_uart_int_id.sv
module tb_uart_int_id;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enh_mode = 1'b0;
    logic [5:0] int_en = '0;
    logic [3:0] rx_err_evt = '0;
    logic       rx_above_trig = 1'b0;
    logic       rx_tmo_evt = 1'b0;
    logic       tx_below_trig = 1'b0;
    logic       tx_trig_zero = 1'b0;
    logic       tx_all_idle = 1'b0;
    logic [3:0] ms_delta_evt = '0;
    logic       spc_match_evt = 1'b0;
    logic       flow_chg = 1'b0;
    logic       isr_rd = 1'b0;
    logic       lsr_rd = 1'b0;
    logic       msr_rd = 1'b0;
    logic       rhr_rd = 1'b0;
    logic [5:0] int_id;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [5:0] C_NONE = 6'b000001, C_LS = 6'b000110, C_RXD = 6'b000100,
                           C_TMO = 6'b001100, C_TX = 6'b000010, C_MS = 6'b000000,
                           C_SPC = 6'b010000, C_FLOW = 6'b100000;

    uart_int_id dut (.*);

    always #4 clk = ~clk;

    // Vector: enh, en[5:0], err, tmo, ms, spc, rxa, flow, txb, expected code
    localparam int NV = 14;
    localparam logic [19:0] VEC [NV] = '{
        {1'b1, 6'h3F, 7'b0000000, C_NONE},
        {1'b1, 6'h3F, 7'b1000000, C_LS},
        {1'b1, 6'h3F, 7'b1111111, C_LS},
        {1'b1, 6'h3F, 7'b0111111, C_RXD},
        {1'b1, 6'h3F, 7'b0111011, C_TMO},
        {1'b1, 6'h3F, 7'b0011011, C_TX},
        {1'b1, 6'h3F, 7'b0011010, C_MS},
        {1'b1, 6'h3F, 7'b0001010, C_SPC},
        {1'b1, 6'h3F, 7'b0000010, C_FLOW},
        {1'b0, 6'h3F, 7'b0001010, C_NONE},
        {1'b1, 6'h3B, 7'b1111111, C_RXD},
        {1'b1, 6'h20, 7'b1111111, C_FLOW},
        {1'b0, 6'h08, 7'b1010000, C_MS},
        {1'b1, 6'h00, 7'b1111111, C_NONE}
    };

    task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic start(input logic enh, input logic [5:0] en);
        rst_n = 1'b0;
        enh_mode = enh; int_en = en;
        rx_err_evt = '0; rx_tmo_evt = 0; ms_delta_evt = '0; spc_match_evt = 0;
        rx_above_trig = 0; flow_chg = 0; tx_below_trig = 0; tx_trig_zero = 0; tx_all_idle = 0;
        isr_rd = 0; lsr_rd = 0; msr_rd = 0; rhr_rd = 0;
        tick();
        rst_n = 1'b1;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        start(1'b1, 6'h3F);
        check("R1 reset code", int_id, C_NONE);
        check("R1 reset irq", {5'b0, irq}, 6'b0);

        // Table of priority and masking patterns (R1 R2 R3 R9 R10 R11)
        for (int i = 0; i < NV; i++) begin
            start(VEC[i][19], VEC[i][18:13]);
            rx_err_evt    = VEC[i][12] ? 4'b0100 : 4'b0000;
            rx_tmo_evt    = VEC[i][11];
            ms_delta_evt  = VEC[i][10] ? 4'b0010 : 4'b0000;
            spc_match_evt = VEC[i][9];
            rx_above_trig = VEC[i][8];
            flow_chg      = VEC[i][7];
            tx_below_trig = VEC[i][6];
            tick();
            rx_err_evt = '0; rx_tmo_evt = 0; ms_delta_evt = '0; spc_match_evt = 0;
            check($sformatf("R2 R11 vector %0d", i), int_id, VEC[i][5:0]);
            check($sformatf("R1 irq vector %0d", i), {5'b0, irq}, {5'b0, VEC[i][5:0] != C_NONE});
        end

        // R4: line status cleared by status read
        start(1'b1, 6'h3F);
        rx_err_evt = 4'b1000; tick(); rx_err_evt = '0;
        check("R4 set", int_id, C_LS);
        lsr_rd = 1; tick(); lsr_rd = 0;
        check("R4 cleared by lsr read", int_id, C_NONE);

        // R5: time-out cleared by holding-register read
        rx_tmo_evt = 1; tick(); rx_tmo_evt = 0;
        check("R5 set", int_id, C_TMO);
        rhr_rd = 1; tick(); rhr_rd = 0;
        check("R5 cleared by rhr read", int_id, C_NONE);

        // R6: transmit empty, identification-read clear and re-arm
        tx_below_trig = 1; tick();
        check("R6 set on rise", int_id, C_TX);
        isr_rd = 1; tick(); isr_rd = 0;
        check("R6 cleared by shown read", int_id, C_NONE);
        tx_below_trig = 0; tick(); tx_below_trig = 1; tick();
        check("R6 re-armed", int_id, C_TX);
        tx_below_trig = 0; tick();
        check("R6 cleared by condition drop", int_id, C_NONE);

        // R7: zero trigger waits for idle transmitter
        tx_trig_zero = 1; tx_below_trig = 1; tx_all_idle = 0; tick();
        check("R7 not idle", int_id, C_NONE);
        tx_all_idle = 1; tick();
        check("R7 idle", int_id, C_TX);
        tx_all_idle = 0; tx_trig_zero = 0; tx_below_trig = 0; tick();

        // R12 / R8: shown-read clears only transmit; modem needs its own read
        start(1'b1, 6'h3F);
        tx_below_trig = 1; ms_delta_evt = 4'b0001; tick(); ms_delta_evt = '0;
        check("R2 tx over modem", int_id, C_TX);
        isr_rd = 1; tick(); isr_rd = 0;
        check("R12 tx cleared, modem shown", int_id, C_MS);
        isr_rd = 1; tick(); isr_rd = 0;
        check("R12 modem kept after isr read", int_id, C_MS);
        msr_rd = 1; tick(); msr_rd = 0;
        check("R8 cleared by msr read", int_id, C_NONE);

        // R9: special character cleared by shown read
        spc_match_evt = 1; tick(); spc_match_evt = 0;
        check("R9 set", int_id, C_SPC);
        isr_rd = 1; tick(); isr_rd = 0;
        check("R9 cleared by shown read", int_id, C_NONE);

        // R11: masked pending flag is kept
        int_en = 6'h37;
        ms_delta_evt = 4'b0100; tick(); ms_delta_evt = '0;
        check("R11 masked", int_id, C_NONE);
        int_en = 6'h3F; #1;
        check("R11 unmasked shows kept flag", int_id, C_MS);
        msr_rd = 1; tick(); msr_rd = 0;

        // R10: flow change hidden in basic mode, shown in enhanced
        start(1'b0, 6'h3F);
        flow_chg = 1; tick();
        check("R10 basic hides flow", int_id, C_NONE);
        enh_mode = 1; #1;
        check("R10 enhanced shows flow", int_id, C_FLOW);
        flow_chg = 0; #1;
        check("R10 follows level", int_id, C_NONE);

        // R3: receive data follows level over pending time-out
        rx_tmo_evt = 1; rx_above_trig = 1; tick(); rx_tmo_evt = 0;
        check("R3 data over timeout", int_id, C_RXD);
        rx_above_trig = 0; #1;
        check("R3 timeout after level drops", int_id, C_TMO);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule